// File: doc/BRIEF.md
# Processor Trap and Reset Sequencer

This block decides when a small processor core leaves its normal instruction flow and enters its trap handler. It watches a synchronous reset, an asynchronous external interrupt pin, and two fault strobes from the memory system. One strobe reports a protection violation. The other reports an address translation that hits an entry whose accessed flag is clear while a locked sequence is in progress.

Every trap, and reset as well, redirects fetch to one fixed handler address. The block owns the status bits that record why the trap happened, the interrupt enable, the user-mode flag and its shadow copies, and three memory-control bits. Reset is the only trap that leaves every cause bit clear, which is how handler software tells it apart from the others. Reset also pulses flush requests for the instruction cache and the translation buffer. At the end of reset the block latches a boot bus-width bit from the interrupt pin.

The block carries no data stream, so it has no valid/ready handshake. All pins are plain control and status lines. Software reaches the status and control words through write strobes with full-word data.

Top module: `trap_sequencer`

## Requirements
- R1: Each trap, reset included, raises `redirect_o` for exactly one cycle while `redirect_pc_o` reads 0xFFFFFF00.
- R2: Reset clears status bits 0 (user mode), 1 (interrupt enable), 2 (break on read), 3 (break on write) and all cause bits 6 (interrupt), 7 (protection), 8 (locked accessed-flag fault). Shadow bits 4 and 5 keep their value.
- R3: Reset clears control bits 0 (page size), 1 (bus lock) and 2 (translation enable).
- R4: On the first clock edge after `rst` falls, `redirect_o`, `icache_flush_o` and `tlb_flush_o` rise together for one cycle, with all cause bits clear. No other trap raises a flush request.
- R5: `boot_narrow_o` holds the value of `irq_pin` at the last clock edge at which `rst` was high.
- R6: `irq_pin` passes through a two-flop synchronizer. A high pin first sampled at edge k is taken at edge k+2 when status bit 1 is set, which sets bit 6. With bit 1 clear the pin has no effect.
- R7: A `prot_fault_i` strobe sampled at an edge traps at that edge and sets status bit 7. A `lock_fault_i` strobe does the same with bit 8.
- R8: Priority is protection fault, then locked fault, then interrupt. Exactly one cause bit is set on a trap, and the other cause bits are cleared.
- R9: Taking a trap copies bit 0 into bit 4 and bit 1 into bit 5, then clears bits 0 and 1.
- R10: Fault and interrupt events are ignored while `rst` is high and on the first edge after it falls.
- R11: `st_wr_i` loads `st_wdata_i` into the status word and `ctl_wr_i` loads `ctl_wdata_i` into the control word. A trap in the same cycle takes precedence over the status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin | input | 1 | External interrupt, asynchronous, also the boot-width sample |
| prot_fault_i | input | 1 | Protection-violation strobe |
| lock_fault_i | input | 1 | Accessed-flag-clear fault inside a locked sequence |
| st_wr_i | input | 1 | Status word write strobe |
| st_wdata_i | input | 9 | Status word write data |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 3 | Control word write data |
| status_o | output | 9 | Status word |
| ctl_o | output | 3 | Control word |
| boot_narrow_o | output | 1 | Boot bus-width bit latched at reset end |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | 32 | Handler address |
| icache_flush_o | output | 1 | Instruction cache flush pulse |
| tlb_flush_o | output | 1 | Translation buffer flush pulse |

## Verification
Faults and status or control writes become visible one cycle after the edge that samples them. An interrupt appears on the third edge after the pin is first seen high, because it crosses two synchronizer flops before the taking edge. The reset pulses belong to the first edge after release, and the boot bit to the last edge with reset high. The bench drives inputs on falling edges and reads outputs 1 ns after the exact rising edge at which each result is due. It also reads them at the edges just before and just after, which confirms both the latency and the one-cycle pulse width.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int ST_W      = 9;
  localparam int ST_USER   = 0;
  localparam int ST_IEN    = 1;
  localparam int ST_BRK_RD = 2;
  localparam int ST_BRK_WR = 3;
  localparam int ST_PUSER  = 4;
  localparam int ST_PIEN   = 5;
  localparam int ST_C_IRQ  = 6;
  localparam int ST_C_PROT = 7;
  localparam int ST_C_LOCK = 8;

  localparam int CTL_W     = 3;

  typedef enum logic [1:0] {
    CZ_NONE = 2'd0,
    CZ_IRQ  = 2'd1,
    CZ_PROT = 2'd2,
    CZ_LOCK = 2'd3
  } cause_e;
endpackage

// File: rtl/trap_seq_sync.sv
module trap_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/trap_seq_arb.sv
module trap_seq_arb
  import trap_seq_pkg::*;
(
  input  logic   hold,
  input  logic   prot_flt,
  input  logic   lock_flt,
  input  logic   irq_req,
  output logic   take,
  output cause_e cause
);
  always_comb begin
    cause = CZ_NONE;
    if (!hold) begin
      if (prot_flt)      cause = CZ_PROT;
      else if (lock_flt) cause = CZ_LOCK;
      else if (irq_req)  cause = CZ_IRQ;
    end
  end

  assign take = (cause != CZ_NONE);
endmodule

// File: rtl/trap_seq_status.sv
module trap_seq_status
  import trap_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  cause_e          cause,
  input  logic            st_wr,
  input  logic [ST_W-1:0] st_wdata,
  input  logic            ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic            boot_pin,
  output logic [ST_W-1:0] st_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic            boot_q
);
  logic [2:0] cause_vec;

  always_comb begin
    cause_vec = 3'b000;
    case (cause)
      CZ_IRQ:  cause_vec = 3'b001;
      CZ_PROT: cause_vec = 3'b010;
      CZ_LOCK: cause_vec = 3'b100;
      default: cause_vec = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q[ST_USER]   <= 1'b0;
      st_q[ST_IEN]    <= 1'b0;
      st_q[ST_BRK_RD] <= 1'b0;
      st_q[ST_BRK_WR] <= 1'b0;
      st_q[ST_C_LOCK:ST_C_IRQ] <= 3'b000;
    end else if (take) begin
      st_q[ST_PUSER] <= st_q[ST_USER];
      st_q[ST_PIEN]  <= st_q[ST_IEN];
      st_q[ST_USER]  <= 1'b0;
      st_q[ST_IEN]   <= 1'b0;
      st_q[ST_C_LOCK:ST_C_IRQ] <= cause_vec;
    end else if (st_wr) begin
      st_q <= st_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) boot_q <= boot_pin;
  end

  // R2
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (st_q[3:0] == 4'b0000) && (st_q[ST_C_LOCK:ST_C_IRQ] == 3'b000));

  // R3
  ctl_clear_chk: assert property (@(posedge clk)
    rst |=> (ctl_q == '0));

  // R9
  trap_mask_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !st_q[ST_IEN] && !st_q[ST_USER]
             && (st_q[ST_PIEN] == $past(st_q[ST_IEN])));
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                PC_W        = 32,
  parameter logic [PC_W-1:0]   HANDLER_PC  = 32'hFFFF_FF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin,
  input  logic              prot_fault_i,
  input  logic              lock_fault_i,
  input  logic              st_wr_i,
  input  logic [8:0]        st_wdata_i,
  input  logic              ctl_wr_i,
  input  logic [2:0]        ctl_wdata_i,
  output logic [8:0]        status_o,
  output logic [2:0]        ctl_o,
  output logic              boot_narrow_o,
  output logic              redirect_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic              icache_flush_o,
  output logic              tlb_flush_o
);
  logic   rst_d;
  logic   irq_s;
  logic   take;
  logic   post_rel;
  cause_e cause;
  logic [ST_W-1:0]  st_q;
  logic [CTL_W-1:0] ctl_q;
  logic   redir_q;
  logic   flush_q;

  always_ff @(posedge clk) rst_d <= rst;
  assign post_rel = rst_d & ~rst;

  trap_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_pin),
    .q   (irq_s)
  );

  trap_seq_arb u_arb (
    .hold     (rst | rst_d),
    .prot_flt (prot_fault_i),
    .lock_flt (lock_fault_i),
    .irq_req  (irq_s & st_q[ST_IEN]),
    .take     (take),
    .cause    (cause)
  );

  trap_seq_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .cause     (cause),
    .st_wr     (st_wr_i),
    .st_wdata  (st_wdata_i),
    .ctl_wr    (ctl_wr_i),
    .ctl_wdata (ctl_wdata_i),
    .boot_pin  (irq_pin),
    .st_q      (st_q),
    .ctl_q     (ctl_q),
    .boot_q    (boot_narrow_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      redir_q <= post_rel | take;
      flush_q <= post_rel;
    end
  end

  assign status_o       = st_q;
  assign ctl_o          = ctl_q;
  assign redirect_o     = redir_q;
  assign redirect_pc_o  = HANDLER_PC;
  assign icache_flush_o = flush_q;
  assign tlb_flush_o    = flush_q;

  // R4
  flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    icache_flush_o |=> !icache_flush_o && !tlb_flush_o);

  // R4
  flush_clean_chk: assert property (@(posedge clk) disable iff (rst)
    icache_flush_o |-> redirect_o && tlb_flush_o
                       && (status_o[ST_C_LOCK:ST_C_IRQ] == 3'b000));

  // R8
  trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && !icache_flush_o) |-> $onehot(status_o[ST_C_LOCK:ST_C_IRQ]));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(status_o[ST_C_IRQ]) && !$past(st_wr_i)) |-> $past(status_o[ST_IEN]));
endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_pin = 1'b0;
  logic        prot_fault_i = 1'b0;
  logic        lock_fault_i = 1'b0;
  logic        st_wr_i = 1'b0;
  logic [8:0]  st_wdata_i = '0;
  logic        ctl_wr_i = 1'b0;
  logic [2:0]  ctl_wdata_i = '0;
  logic [8:0]  status_o;
  logic [2:0]  ctl_o;
  logic        boot_narrow_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic        icache_flush_o;
  logic        tlb_flush_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_sequencer u_dut (
    .clk(clk), .rst(rst), .irq_pin(irq_pin),
    .prot_fault_i(prot_fault_i), .lock_fault_i(lock_fault_i),
    .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .status_o(status_o), .ctl_o(ctl_o), .boot_narrow_o(boot_narrow_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .icache_flush_o(icache_flush_o), .tlb_flush_o(tlb_flush_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_st(logic [8:0] v);
    @(negedge clk); st_wr_i = 1'b1; st_wdata_i = v;
    @(negedge clk); st_wr_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R10 R1
  task automatic do_reset(bit bootv);
    @(negedge clk); rst = 1'b1; irq_pin = bootv; prot_fault_i = 1'b1;
    tick(); tick(); tick();
    check("R10 no redirect in reset", {31'd0, redirect_o}, 32'd0);
    @(negedge clk); rst = 1'b0; irq_pin = 1'b0;
    tick();
    check("R4 redirect after release", {31'd0, redirect_o}, 32'd1);
    check("R4 icache flush", {31'd0, icache_flush_o}, 32'd1);
    check("R4 tlb flush", {31'd0, tlb_flush_o}, 32'd1);
    check("R1 handler pc", redirect_pc_o, 32'hFFFF_FF00);
    check("R2 reset-cleared status", {23'd0, status_o & 9'h1CF}, 32'd0);
    check("R3 control cleared", {29'd0, ctl_o}, 32'd0);
    check("R5 boot bit", {31'd0, boot_narrow_o}, {31'd0, bootv});
    @(negedge clk); prot_fault_i = 1'b0;
    tick();
    check("R4 pulse ends", {29'd0, redirect_o, icache_flush_o, tlb_flush_o}, 32'd0);
    check("R10 fault on release edge ignored", {23'd0, status_o & 9'h1C0}, 32'd0);
  endtask

  // R2 shadow bits survive reset, R3 control write then clear, R11
  task automatic t_shadow_ctl();
    write_st(9'h1FF);
    check("R11 status write", {23'd0, status_o}, 32'h1FF);
    @(negedge clk); ctl_wr_i = 1'b1; ctl_wdata_i = 3'b111;
    @(negedge clk); ctl_wr_i = 1'b0;
    check("R11 control write", {29'd0, ctl_o}, 32'd7);
    do_reset(1'b0);
    check("R2 shadow kept", {23'd0, status_o}, 32'h030);
    check("R3 control after reset", {29'd0, ctl_o}, 32'd0);
  endtask

  // R6 masked
  task automatic t_irq_masked();
    write_st(9'h000);
    @(negedge clk); irq_pin = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R6 masked no redirect", {31'd0, redirect_o}, 32'd0);
    end
    check("R6 masked status", {23'd0, status_o}, 32'd0);
    @(negedge clk); irq_pin = 1'b0;
    repeat (3) tick();
  endtask

  // R6 R9 R1 R4
  task automatic t_irq_taken();
    write_st(9'h002);
    @(negedge clk); irq_pin = 1'b1;
    tick();
    check("R6 no redirect edge k", {31'd0, redirect_o}, 32'd0);
    tick();
    check("R6 no redirect edge k+1", {31'd0, redirect_o}, 32'd0);
    tick();
    check("R6 redirect edge k+2", {31'd0, redirect_o}, 32'd1);
    check("R6 R9 status after irq", {23'd0, status_o}, 32'h060);
    check("R4 no flush on irq", {31'd0, icache_flush_o}, 32'd0);
    @(negedge clk); irq_pin = 1'b0;
    tick();
    check("R1 irq pulse one cycle", {31'd0, redirect_o}, 32'd0);
    repeat (3) tick();
  endtask

  // R7 R9
  task automatic t_faults();
    write_st(9'h003);
    @(negedge clk); prot_fault_i = 1'b1;
    tick();
    check("R7 prot redirect", {31'd0, redirect_o}, 32'd1);
    check("R7 R9 prot status", {23'd0, status_o}, 32'h0B0);
    @(negedge clk); prot_fault_i = 1'b0;
    tick();
    check("R1 prot pulse ends", {31'd0, redirect_o}, 32'd0);
    write_st(9'h000);
    @(negedge clk); lock_fault_i = 1'b1;
    tick();
    check("R7 lock redirect", {31'd0, redirect_o}, 32'd1);
    check("R7 lock status", {23'd0, status_o}, 32'h100);
    @(negedge clk); lock_fault_i = 1'b0;
    tick();
  endtask

  // R8
  task automatic t_priority();
    write_st(9'h002);
    @(negedge clk); irq_pin = 1'b1;
    tick(); tick();
    @(negedge clk); prot_fault_i = 1'b1; lock_fault_i = 1'b1;
    tick();
    check("R8 prot wins", {23'd0, status_o}, 32'h0A0);
    @(negedge clk); prot_fault_i = 1'b0; lock_fault_i = 1'b0; irq_pin = 1'b0;
    repeat (3) tick();
    write_st(9'h002);
    @(negedge clk); irq_pin = 1'b1;
    tick(); tick();
    @(negedge clk); lock_fault_i = 1'b1;
    tick();
    check("R8 lock over irq", {23'd0, status_o}, 32'h120);
    @(negedge clk); lock_fault_i = 1'b0; irq_pin = 1'b0;
    repeat (3) tick();
  endtask

  // R11 trap beats write
  task automatic t_write_race();
    write_st(9'h002);
    @(negedge clk); st_wr_i = 1'b1; st_wdata_i = 9'h00F; prot_fault_i = 1'b1;
    tick();
    check("R11 trap beats write", {23'd0, status_o}, 32'h0A0);
    @(negedge clk); st_wr_i = 1'b0; prot_fault_i = 1'b0;
    tick();
  endtask

  initial begin
    do_reset(1'b1);
    t_shadow_ctl();
    t_irq_masked();
    t_irq_taken();
    t_faults();
    t_priority();
    t_write_race();
    do_reset(1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule